// File: doc/BRIEF.md
# Flash Write-Buffer Load Controller

This block takes in a multi-write sequence that programs up to sixteen words of a flash word array in one operation. After a pre-decoded unlock pulse, the host writes a load command at a sector address. It then writes the number of words to follow, minus one. Next come the address/data pairs, which may arrive in any order. The first of these fixes a sixteen-word page, and every later pair must land in that same page. A confirm command at the sector address then starts programming.

The pairs are kept in a local buffer with a valid bit for each entry. During programming, each valid entry is ANDed into the word array, one entry per cycle, inside a fixed-length busy window. A write can only clear bits and never set them. The unlock step, the count, the page, the number of loads and the confirm word are all checked. A violation raises a sticky abort flag, drops the sequence and leaves the array untouched.

The write interface uses valid/ready. A write is taken on a clock edge where both `wr_valid` and `wr_ready` are high. `wr_ready` is low for the whole programming window, so the host must hold its write until ready returns. Outside that window, ready is always high. Writes that do not match the expected step are accepted and then either dropped or turned into an abort, as the requirements list.

Top module: `wbuf_prog_ctrl`

## Requirements
- R1: After reset, `busy`, `aborted` and `arr_we` are low, `wr_ready` is high, and every array word reads 16'hFFFF.
- R2: Outside an armed sequence, writes have no effect. A sequence is armed only by `unlock_pulse`. The first write after the unlock must carry data 16'h0025 (load command); any other data returns the controller quietly to idle, with no abort. The sector of that write is `wr_addr[7:6]`.
- R3: The next write must be in the same sector and carry a count of 0 to 15. A count above 15, or a different sector, aborts.
- R4: The first data load sets the page to `wr_addr[7:4]` and must be in the command's sector. Any later load whose `wr_addr[7:4]` differs aborts.
- R5: Every data load uses up one count, even a repeat of an address. A repeated address keeps the last data written. After count+1 loads, the controller expects the confirm.
- R6: The confirm must carry data 16'h0029 in the command's sector, which starts programming. Any other write at that step aborts.
- R7: Programming holds `busy` high and `wr_ready` low for exactly 24 cycles (16 + 8). `toggle` inverts on every busy cycle.
- R8: During programming, each loaded buffer entry i sets array word {page, i} to old & data. Words that were not loaded stay unchanged.
- R9: An abort sets `aborted`, returns to idle and leaves the array unchanged. `aborted` stays set until the next accepted load command clears it.
- R10: If `unlock_pulse` and a write handshake fall in the same idle cycle, the unlock arms the sequence and the write is discarded.
- R11: `last_addr` shows the address of the most recent accepted data load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unlock_pulse | input | 1 | One-cycle pulse marking a completed unlock |
| wr_valid | input | 1 | Host write valid |
| wr_ready | output | 1 | Write accepted when high with valid; low while programming |
| wr_addr | input | 8 | Write word address |
| wr_data | input | 16 | Write data or command |
| arr_we | output | 1 | Array write strobe during commit |
| arr_addr | output | 8 | Array write address |
| arr_wdata | output | 16 | Array write data (old word ANDed with buffered word) |
| rd_addr | input | 8 | Array read address |
| rd_data | output | 16 | Array read data (combinational) |
| busy | output | 1 | Programming window active |
| toggle | output | 1 | Inverts every busy cycle |
| aborted | output | 1 | Sticky abort status |
| last_addr | output | 8 | Address of the most recent data load |

## Verification
The two functions that can fall in one cycle are arming by `unlock_pulse` and acceptance of a host write while idle. The bench raises both in the same cycle, with the write carrying the load command. It then sends a fresh load command and a full sequence. The case passes only if that sequence programs the array exactly as the bench model predicts, which shows that the unlock was kept and the same-cycle write was dropped. A second collision is also covered: a repeated address that is also the final load. Here the bench checks that the last value wins and that the confirm is expected right after it.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ARMED, S_COUNT, S_LOAD, S_CONFIRM, S_PROG
  } seq_state_e;

  localparam logic [7:0] CMD_LOAD    = 8'h25;
  localparam logic [7:0] CMD_CONFIRM = 8'h29;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_mask,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [DW-1:0]    ld_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid
);
  logic [DW-1:0]    entry_q [DEPTH];
  logic [DEPTH-1:0] valid_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        entry_q[i] <= '0;
        valid_q[i] <= 1'b0;
      end else if (clr_mask) begin
        valid_q[i] <= 1'b0;
      end else if (ld_en && ld_idx == IDX_W'(i)) begin
        entry_q[i] <= ld_data;
        valid_q[i] <= 1'b1;
      end
    end
  end

  assign rd_data  = entry_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];

  // R5: a load always leaves its entry marked valid
  p_load_marks_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !clr_mask) |=> valid_q[$past(ld_idx)]);
endmodule

// File: rtl/wbuf_array.sv
module wbuf_array #(
  parameter int AW = 8,
  parameter int DW = 16,
  localparam int WORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] caddr,
  output logic [DW-1:0] cdata,
  input  logic [AW-1:0] xaddr,
  output logic [DW-1:0] xdata
);
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign cdata = mem_q[caddr];
  assign xdata = mem_q[xaddr];

  // R8: a commit may clear bits but never set one
  p_and_only_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ((wdata & ~mem_q[waddr]) == '0));
endmodule

// File: rtl/wbuf_seq.sv
module wbuf_seq
  import wbuf_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 16,
  parameter int DEPTH      = 16,
  parameter int SECT_LSB   = 6,
  parameter int PROG_EXTRA = 8,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int PG_W     = AW - IDX_W,
  localparam int SC_W     = AW - SECT_LSB,
  localparam int CNT_W    = IDX_W + 1,
  localparam int PROG_LEN = DEPTH + PROG_EXTRA,
  localparam int PC_W     = $clog2(PROG_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unlock,
  input  logic             wr_fire,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output seq_state_e       state,
  output logic             clr_mask,
  output logic             ld_en,
  output logic [PG_W-1:0]  page,
  output logic             commit_en,
  output logic [IDX_W-1:0] commit_idx,
  output logic             aborted,
  output logic             toggle,
  output logic [AW-1:0]    last_addr
);
  seq_state_e       state_q, state_d;
  logic [SC_W-1:0]  sect_q;
  logic [PG_W-1:0]  page_q;
  logic [CNT_W-1:0] remain_q;
  logic             first_q;
  logic [PC_W-1:0]  pc_q;
  logic             aborted_q, tog_q;
  logic [AW-1:0]    last_q;

  logic [SC_W-1:0] addr_sect;
  logic [PG_W-1:0] addr_page;
  logic            sect_hit, page_hit, is_load_cmd, is_conf_cmd, count_ok;
  logic            load_ok, abort_evt, accept_cmd, accept_cnt, accept_conf;

  assign addr_sect   = wr_addr[AW-1:SECT_LSB];
  assign addr_page   = wr_addr[AW-1:IDX_W];
  assign sect_hit    = (addr_sect == sect_q);
  assign page_hit    = (addr_page == page_q);
  assign is_load_cmd = (wr_data == DW'(CMD_LOAD));
  assign is_conf_cmd = (wr_data == DW'(CMD_CONFIRM));
  assign count_ok    = (wr_data <= DW'(DEPTH - 1));
  assign load_ok     = first_q ? sect_hit : page_hit;

  always_comb begin
    state_d     = state_q;
    abort_evt   = 1'b0;
    ld_en       = 1'b0;
    clr_mask    = 1'b0;
    accept_cmd  = 1'b0;
    accept_cnt  = 1'b0;
    accept_conf = 1'b0;
    unique case (state_q)
      S_IDLE: if (unlock) state_d = S_ARMED;
      S_ARMED: if (wr_fire) begin
        if (is_load_cmd) begin
          state_d    = S_COUNT;
          accept_cmd = 1'b1;
        end else begin
          state_d = S_IDLE;
        end
      end
      S_COUNT: if (wr_fire) begin
        if (sect_hit && count_ok) begin
          state_d    = S_LOAD;
          clr_mask   = 1'b1;
          accept_cnt = 1'b1;
        end else begin
          abort_evt = 1'b1;
        end
      end
      S_LOAD: if (wr_fire) begin
        if (load_ok) begin
          ld_en = 1'b1;
          if (remain_q == CNT_W'(1)) state_d = S_CONFIRM;
        end else begin
          abort_evt = 1'b1;
        end
      end
      S_CONFIRM: if (wr_fire) begin
        if (is_conf_cmd && sect_hit) begin
          state_d     = S_PROG;
          accept_conf = 1'b1;
        end else begin
          abort_evt = 1'b1;
        end
      end
      S_PROG: if (pc_q == PC_W'(PROG_LEN - 1)) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (abort_evt) state_d = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      sect_q    <= '0;
      page_q    <= '0;
      remain_q  <= '0;
      first_q   <= 1'b0;
      pc_q      <= '0;
      aborted_q <= 1'b0;
      tog_q     <= 1'b0;
      last_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept_cmd) begin
        sect_q    <= addr_sect;
        aborted_q <= 1'b0;
      end
      if (accept_cnt) begin
        remain_q <= wr_data[CNT_W-1:0] + CNT_W'(1);
        first_q  <= 1'b1;
      end
      if (ld_en) begin
        if (first_q) page_q <= addr_page;
        first_q  <= 1'b0;
        remain_q <= remain_q - CNT_W'(1);
        last_q   <= wr_addr;
      end
      if (accept_conf) pc_q <= '0;
      if (state_q == S_PROG) begin
        pc_q  <= pc_q + PC_W'(1);
        tog_q <= ~tog_q;
      end
      if (abort_evt) aborted_q <= 1'b1;
    end
  end

  assign state      = state_q;
  assign page       = page_q;
  assign commit_en  = (state_q == S_PROG) && (pc_q < PC_W'(DEPTH));
  assign commit_idx = pc_q[IDX_W-1:0];
  assign aborted    = aborted_q;
  assign toggle     = tog_q;
  assign last_addr  = last_q;

  // R9: a fresh abort always lands in idle
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aborted_q) |-> (state_q == S_IDLE));
  // R3: an oversized count is never accepted
  p_oversize_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_COUNT && wr_fire && !count_ok) |=> (aborted_q && state_q == S_IDLE));
  // R4: a load outside the chosen page aborts
  p_page_mismatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_LOAD && wr_fire && !first_q && !page_hit) |=> (aborted_q && state_q == S_IDLE));
  // R7: the programming counter stays inside its window
  p_prog_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_PROG) |-> (pc_q < PC_W'(PROG_LEN)));
  // R5: the confirm step is reached only with the count used up
  p_count_used_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CONFIRM) |-> (remain_q == '0));
endmodule

// File: rtl/wbuf_prog_ctrl.sv
module wbuf_prog_ctrl
  import wbuf_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 16,
  parameter int DEPTH      = 16,
  parameter int SECT_LSB   = 6,
  parameter int PROG_EXTRA = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PG_W  = AW - IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unlock_pulse,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          toggle,
  output logic          aborted,
  output logic [AW-1:0] last_addr
);
  seq_state_e       state;
  logic             clr_mask, ld_en, commit_en, ent_valid, wr_fire;
  logic [PG_W-1:0]  page;
  logic [IDX_W-1:0] commit_idx;
  logic [DW-1:0]    ent_data, old_word;

  assign busy     = (state == S_PROG);
  assign wr_ready = !busy;
  assign wr_fire  = wr_valid && wr_ready;

  wbuf_seq #(
    .AW(AW), .DW(DW), .DEPTH(DEPTH), .SECT_LSB(SECT_LSB), .PROG_EXTRA(PROG_EXTRA)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .unlock(unlock_pulse), .wr_fire(wr_fire),
    .wr_addr(wr_addr), .wr_data(wr_data), .state(state), .clr_mask(clr_mask),
    .ld_en(ld_en), .page(page), .commit_en(commit_en), .commit_idx(commit_idx),
    .aborted(aborted), .toggle(toggle), .last_addr(last_addr)
  );

  wbuf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr_mask(clr_mask), .ld_en(ld_en),
    .ld_idx(wr_addr[IDX_W-1:0]), .ld_data(wr_data), .rd_idx(commit_idx),
    .rd_data(ent_data), .rd_valid(ent_valid)
  );

  assign arr_we    = commit_en && ent_valid;
  assign arr_addr  = {page, commit_idx};
  assign arr_wdata = old_word & ent_data;

  wbuf_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(arr_addr), .wdata(arr_wdata),
    .caddr(arr_addr), .cdata(old_word), .xaddr(rd_addr), .xdata(rd_data)
  );

  // R8: the array is written only inside the programming window
  p_write_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  // R7: no write is taken while programming
  p_stall_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_fire);
endmodule

// File: tb/wbuf_prog_ctrl_test.sv
module wbuf_prog_ctrl_test;
  localparam int PROG_LEN = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        unlock_pulse = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        arr_we;
  logic [7:0]  arr_addr;
  logic [15:0] arr_wdata;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        busy, toggle, aborted;
  logic [7:0]  last_addr;

  int total = 0;
  int bad = 0;
  logic [15:0] model [256];
  logic [15:0] bbuf [16];
  logic        bval [16];

  always #2 clk = ~clk;

  wbuf_prog_ctrl uut (
    .clk(clk), .rst_n(rst_n), .unlock_pulse(unlock_pulse), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .toggle(toggle), .aborted(aborted), .last_addr(last_addr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic unlock();
    @(negedge clk);
    unlock_pulse = 1'b1;
    @(negedge clk);
    unlock_pulse = 1'b0;
  endtask

  task automatic check_array(input string req);
    int miss = 0;
    int first = -1;
    for (int a = 0; a < 256; a++) begin
      rd_addr = 8'(a);
      #0.1;
      if (rd_data !== model[a]) begin
        miss++;
        if (first < 0) first = a;
      end
    end
    if (first < 0) chk(1'b1, req, "array", 0, 0);
    else begin
      rd_addr = 8'(first);
      #0.1;
      chk(1'b0, req, $sformatf("array word %0h", first), int'(rd_data), int'(model[first]));
    end
  endtask

  task automatic clear_bbuf();
    for (int i = 0; i < 16; i++) begin bbuf[i] = '0; bval[i] = 1'b0; end
  endtask

  task automatic load(input logic [7:0] a, input logic [15:0] d);
    wr(a, d);
    bbuf[a[3:0]] = d;
    bval[a[3:0]] = 1'b1;
  endtask

  // confirm, then observe the busy window and fold the buffer into the model
  task automatic confirm_and_prog(input logic [7:0] sa, input logic [3:0] pg);
    int cyc = 0;
    bit tog_ok = 1'b1;
    bit rdy_ok = 1'b1;
    logic prev_tog;
    wr(sa, 16'h0029);
    prev_tog = toggle;
    while (busy && cyc < 100) begin
      if (wr_ready) rdy_ok = 1'b0;
      @(negedge clk);
      cyc++;
      if (busy && toggle == prev_tog) tog_ok = 1'b0;
      prev_tog = toggle;
    end
    chk(cyc == PROG_LEN, "R7", "busy cycles", cyc, PROG_LEN);
    chk(tog_ok && rdy_ok, "R7", "toggle/ready in window", {tog_ok, rdy_ok}, 2'b11);
    for (int i = 0; i < 16; i++)
      if (bval[i]) model[{pg, 4'(i)}] &= bbuf[i];
  endtask

  task automatic expect_abort(input string req);
    @(negedge clk);
    chk(aborted === 1'b1 && busy === 1'b0, req, "abort flag/idle", {aborted, busy}, 2'b10);
    check_array(req);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) model[a] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!busy && wr_ready && !aborted && !arr_we, "R1", "reset outputs",
        {busy, wr_ready, aborted, arr_we}, 4'b0100);
    check_array("R1");

    // R2: writes without unlock are ignored
    wr(8'h40, 16'h0025); wr(8'h40, 16'h0003); wr(8'h40, 16'h0029);
    @(negedge clk);
    chk(!busy && !aborted, "R2", "no unlock no effect", {busy, aborted}, 0);
    check_array("R2");
    // R2: wrong data after unlock returns quietly to idle
    unlock(); wr(8'h40, 16'h0024); wr(8'h40, 16'h0025); wr(8'h40, 16'h0000);
    @(negedge clk);
    chk(!busy && !aborted, "R2", "bad cmd quiet idle", {busy, aborted}, 0);

    // R8/R5/R11: sweep every count over distinct pages
    for (int n = 0; n < 16; n++) begin
      logic [3:0] pg = 4'((n * 3 + 1) % 16);
      logic [7:0] sa = {pg[3:2], 6'(n)};
      logic [7:0] la = '0;
      clear_bbuf();
      unlock(); wr(sa, 16'h0025); wr(sa, 16'(n));
      for (int k = 0; k <= n; k++) begin
        la = {pg, 4'((k * 7 + n) % 16)};
        load(la, 16'hFFFF ^ (16'h1 << ((k * 3 + n) % 16)) ^ (16'h1 << (n % 16)));
      end
      chk(last_addr == la, "R11", "last_addr", last_addr, la);
      confirm_and_prog(sa, pg);
      chk(!aborted, "R6", "no abort on good confirm", aborted, 0);
      check_array("R8");
    end

    // R5: repeats consume the count; last value wins; final load is a repeat
    clear_bbuf();
    unlock(); wr(8'h80, 16'h0025); wr(8'h81, 16'h0003);
    load(8'h92, 16'h0F0F); load(8'h95, 16'h7FFE); load(8'h92, 16'hFF00); load(8'h92, 16'hAAAA);
    chk(last_addr == 8'h92, "R11", "last_addr repeat", last_addr, 8'h92);
    confirm_and_prog(8'hBF, 4'h9);
    check_array("R5");

    // R3: oversized count
    unlock(); wr(8'h00, 16'h0025); wr(8'h00, 16'h0010);
    expect_abort("R3");
    // R9: next load command clears the flag
    unlock(); wr(8'h00, 16'h0025);
    @(negedge clk);
    chk(!aborted, "R9", "flag cleared by load cmd", aborted, 0);
    // R3: count written in another sector
    wr(8'h40, 16'h0002);
    expect_abort("R3");
    // R4: first load outside the sector
    unlock(); wr(8'h00, 16'h0025); wr(8'h00, 16'h0002); wr(8'h50, 16'h0000);
    expect_abort("R4");
    // R4: later load in another page of the same sector (R9: array unchanged)
    unlock(); wr(8'h00, 16'h0025); wr(8'h00, 16'h0002); wr(8'h03, 16'h0000); wr(8'h13, 16'h0000);
    expect_abort("R4");
    // R6: wrong confirm data
    unlock(); wr(8'h00, 16'h0025); wr(8'h00, 16'h0000); wr(8'h05, 16'h0000); wr(8'h00, 16'h0028);
    expect_abort("R6");
    // R6: confirm in another sector
    unlock(); wr(8'h00, 16'h0025); wr(8'h00, 16'h0000); wr(8'h05, 16'h0000); wr(8'hC0, 16'h0029);
    expect_abort("R6");

    // R10: unlock and a write in one idle cycle
    clear_bbuf();
    @(negedge clk);
    unlock_pulse = 1'b1; wr_valid = 1'b1; wr_addr = 8'hC0; wr_data = 16'h0025;
    @(negedge clk);
    unlock_pulse = 1'b0; wr_valid = 1'b0;
    wr(8'hC0, 16'h0025); wr(8'hC0, 16'h0001);
    load(8'hE4, 16'h1234); load(8'hE9, 16'hFFF0);
    confirm_and_prog(8'hC0, 4'hE);
    chk(!aborted, "R10", "collision sequence clean", aborted, 0);
    check_array("R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule